// File: doc/BRIEF.md
# Deep Idle Power-Down Sequencer

This block walks a single processor core into its lowest idle state and back out again. A software idle request starts the entry. The sequencer asks the last-level cache to shrink and the state-transfer engine to copy core state into an always-powered store. It then tells the chipset that the core is going down. After the chipset acknowledges that it has stopped the core clock and fenced I/O, the sequencer lowers the regulator voltage code and parks the core. While the core is parked, snoops raised by DMA traffic are held off and do not wake it.

Only a break event forwarded by the chipset brings the core back. On exit the regulator is raised and the sequencer waits for it to report ready. It then holds the core in internal reset until the PLL locks, triggers the restore of saved state and cache re-expansion, and finally gives a one-cycle resume pulse so execution continues at the next instruction. If a break event arrives before the regulator is lowered, entry is abandoned and the sequencer goes straight to the restore step without an internal reset.

Every handshake wait has a programmable timeout. On expiry the sequencer raises an error flag and falls back to the active phase. The transfer engine, the store and the regulator are outside the block; the block sees them only as handshake signals.

Top module: `core_sleep_seq`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `phase` is 0 (active), every command output is low, and `err` and `resume` are low.
- R2: In phase 0, `idle_req` moves the block to phase 1 (save), where `save_go` and `cache_shrink` are high. In phase 1, `save_done` moves it to phase 2 (entry handshake), where `cs_enter` is high.
- R3: In phase 2, `cs_ack` moves the block to phase 3 (regulator down), where `vid_low` and `snoop_blk` are high. In phase 3, `vr_ready` going low moves it to phase 4 (deep).
- R4: Phase 4 keeps `vid_low` and `snoop_blk` high and `snoop_fwd` low whatever `snoop_req` does. It has no timeout, and only `wake_irq` moves the block on, to phase 5 (wake), where `vid_low` is low.
- R5: In phase 5, `vr_ready` moves the block to phase 6 (reset), where `core_rst` is high. In phase 6, `pll_lock` moves it to phase 7 (restore), where `restore_go` and `cache_expand` are high. In phase 7, `restore_done` returns it to phase 0, with `resume` high for exactly that first cycle.
- R6: `wake_irq` in phase 1 or phase 2 moves the block directly to phase 7, skipping phases 3 to 6 and never asserting `core_rst`.
- R7: In a timed phase (1, 2, 3, 5, 6, 7), with limit L on `tmo_limit`, the block stays in that phase for L+1 cycles if no progress input arrives, then returns to phase 0 with `err` high.
- R8: `err` stays high in phase 0 until the next accepted `idle_req`, which clears it on the same edge that enters phase 1.
- R9: On the same cycle, an abort by `wake_irq` takes priority over progress, and progress takes priority over the timeout at its final cycle.
- R10: Outside phases 3 to 6, `snoop_fwd` follows `snoop_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| idle_req | input | 1 | Software idle request |
| save_done | input | 1 | State save finished |
| cs_ack | input | 1 | Chipset has stopped the clock and fenced I/O |
| vr_ready | input | 1 | Regulator at its operating voltage |
| wake_irq | input | 1 | Break event forwarded by the chipset |
| pll_lock | input | 1 | PLL locked |
| restore_done | input | 1 | State restore finished |
| snoop_req | input | 1 | Incoming DMA snoop |
| tmo_limit | input | TW | Handshake timeout limit in cycles |
| save_go | output | 1 | Start the state save |
| cache_shrink | output | 1 | Shrink the last-level cache |
| cs_enter | output | 1 | Tell the chipset to take the core down |
| vid_low | output | 1 | Regulator voltage code at the off level |
| snoop_blk | output | 1 | Snoops held off |
| core_rst | output | 1 | Internal core reset |
| restore_go | output | 1 | Start the state restore |
| cache_expand | output | 1 | Re-expand the last-level cache |
| resume | output | 1 | One-cycle resume pulse |
| err | output | 1 | Handshake timeout occurred |
| snoop_fwd | output | 1 | Snoop passed through to the core |
| phase | output | 3 | Current phase code, 0 to 7 |

## Verification
The assertions assume that the regulator, chipset and state engine answer only within the protocol. In particular, `wake_irq` is the only input that may move the block out of the deep phase, and `rst_n` is held for at least one clock. The stimulus drives each handshake input for a single cycle, and only in the phase that waits for it. It lowers `vr_ready` only after the voltage code has been lowered, and raises it again before the next entry, so the regulator never appears to switch on its own. Timeout limits are swept over small values so that every count up to the expiry cycle is observed.

// File: rtl/sleep_seq_pkg.sv
package sleep_seq_pkg;

   typedef enum logic [2:0] {
      PH_ACTIVE   = 3'd0,
      PH_SAVE     = 3'd1,
      PH_ENTRY_HS = 3'd2,
      PH_VR_DOWN  = 3'd3,
      PH_DEEP     = 3'd4,
      PH_WAKE     = 3'd5,
      PH_RESET    = 3'd6,
      PH_RESTORE  = 3'd7
   } phase_e;

   // phases that wait on an external handshake and so carry a timeout
   function automatic logic is_timed(phase_e p);
      return (p != PH_ACTIVE) && (p != PH_DEEP);
   endfunction

endpackage

// File: rtl/sleep_wait_timer.sv
module sleep_wait_timer #(
   parameter int TW     = 8,
   parameter bit TMO_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart,
   input  logic          timed,
   input  logic [TW-1:0] limit,
   output logic          expire
);
   localparam logic [TW-1:0] CNT_MAX = '1;

   generate
      if (TMO_EN) begin : g_count
         logic [TW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          cnt <= '0;
            else if (restart)                    cnt <= '0;
            else if (timed && cnt != CNT_MAX)    cnt <= cnt + 1'b1;
         end
         assign expire = timed && (cnt == limit);
      end else begin : g_none
         assign expire = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/sleep_out_decode.sv
module sleep_out_decode
   import sleep_seq_pkg::*;
(
   input  phase_e ph,
   output logic   save_go,
   output logic   cache_shrink,
   output logic   cs_enter,
   output logic   vid_low,
   output logic   snoop_blk,
   output logic   core_rst,
   output logic   restore_go,
   output logic   cache_expand
);
   always_comb begin
      save_go      = (ph == PH_SAVE);
      cache_shrink = (ph == PH_SAVE);
      cs_enter     = (ph == PH_ENTRY_HS);
      vid_low      = (ph == PH_VR_DOWN) || (ph == PH_DEEP);
      snoop_blk    = (ph == PH_VR_DOWN) || (ph == PH_DEEP) ||
                     (ph == PH_WAKE)    || (ph == PH_RESET);
      core_rst     = (ph == PH_RESET);
      restore_go   = (ph == PH_RESTORE);
      cache_expand = (ph == PH_RESTORE);
   end
endmodule

// File: rtl/core_sleep_seq.sv
module core_sleep_seq
   import sleep_seq_pkg::*;
#(
   parameter int TW       = 8,
   parameter bit TMO_EN   = 1'b1,
   parameter bit ABORT_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          idle_req,
   input  logic          save_done,
   input  logic          cs_ack,
   input  logic          vr_ready,
   input  logic          wake_irq,
   input  logic          pll_lock,
   input  logic          restore_done,
   input  logic          snoop_req,
   input  logic [TW-1:0] tmo_limit,
   output logic          save_go,
   output logic          cache_shrink,
   output logic          cs_enter,
   output logic          vid_low,
   output logic          snoop_blk,
   output logic          core_rst,
   output logic          restore_go,
   output logic          cache_expand,
   output logic          resume,
   output logic          err,
   output logic          snoop_fwd,
   output logic [2:0]    phase
);
   generate
      if (TW < 2 || TW > 32) begin : g_bad_tw
         $error("core_sleep_seq: TW must lie in 2..32");
      end
   endgenerate

   phase_e cur, nxt;
   logic   tmo, brk, tmo_hit, done_hit;

   generate
      if (ABORT_EN) begin : g_abort
         assign brk = wake_irq;
      end else begin : g_no_abort
         assign brk = 1'b0;
      end
   endgenerate

   always_comb begin
      nxt      = cur;
      tmo_hit  = 1'b0;
      done_hit = 1'b0;
      unique case (cur)
         PH_ACTIVE:   if (idle_req) nxt = PH_SAVE;
         PH_SAVE: begin
            if (brk)            nxt = PH_RESTORE;
            else if (save_done) nxt = PH_ENTRY_HS;
            else if (tmo)       begin nxt = PH_ACTIVE; tmo_hit = 1'b1; end
         end
         PH_ENTRY_HS: begin
            if (brk)            nxt = PH_RESTORE;
            else if (cs_ack)    nxt = PH_VR_DOWN;
            else if (tmo)       begin nxt = PH_ACTIVE; tmo_hit = 1'b1; end
         end
         PH_VR_DOWN: begin
            if (!vr_ready)      nxt = PH_DEEP;
            else if (tmo)       begin nxt = PH_ACTIVE; tmo_hit = 1'b1; end
         end
         PH_DEEP:     if (wake_irq) nxt = PH_WAKE;
         PH_WAKE: begin
            if (vr_ready)       nxt = PH_RESET;
            else if (tmo)       begin nxt = PH_ACTIVE; tmo_hit = 1'b1; end
         end
         PH_RESET: begin
            if (pll_lock)       nxt = PH_RESTORE;
            else if (tmo)       begin nxt = PH_ACTIVE; tmo_hit = 1'b1; end
         end
         PH_RESTORE: begin
            if (restore_done)   begin nxt = PH_ACTIVE; done_hit = 1'b1; end
            else if (tmo)       begin nxt = PH_ACTIVE; tmo_hit = 1'b1; end
         end
         default:             nxt = PH_ACTIVE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur    <= PH_ACTIVE;
         err    <= 1'b0;
         resume <= 1'b0;
      end else begin
         cur    <= nxt;
         resume <= done_hit;
         if (tmo_hit)                         err <= 1'b1;
         else if (cur == PH_ACTIVE && idle_req) err <= 1'b0;
      end
   end

   sleep_wait_timer #(.TW(TW), .TMO_EN(TMO_EN)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (nxt != cur),
      .timed   (is_timed(cur)),
      .limit   (tmo_limit),
      .expire  (tmo)
   );

   sleep_out_decode u_dec (
      .ph           (cur),
      .save_go      (save_go),
      .cache_shrink (cache_shrink),
      .cs_enter     (cs_enter),
      .vid_low      (vid_low),
      .snoop_blk    (snoop_blk),
      .core_rst     (core_rst),
      .restore_go   (restore_go),
      .cache_expand (cache_expand)
   );

   assign snoop_fwd = snoop_req && !snoop_blk;
   assign phase     = cur;
endmodule

// File: rtl/core_sleep_seq_chk.sv
module core_sleep_seq_chk
   import sleep_seq_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       wake_irq,
   input logic [2:0] phase,
   input logic       save_go,
   input logic       cs_enter,
   input logic       core_rst,
   input logic       restore_go,
   input logic       vid_low,
   input logic       snoop_blk,
   input logic       snoop_fwd,
   input logic       resume,
   input logic       err
);
   p_cmd_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({save_go, cs_enter, core_rst, restore_go}));

   p_deep_fenced_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_DEEP) |-> (vid_low && snoop_blk && !snoop_fwd));

   p_deep_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_DEEP && !wake_irq) |=> (phase == PH_DEEP));

   p_wake_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_WAKE && $past(phase) != PH_WAKE) |-> ($past(phase) == PH_DEEP));

   p_resume_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
      resume |=> !resume);

   p_resume_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
      resume |-> (phase == PH_ACTIVE));

   p_restore_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_RESTORE && $past(phase) != PH_RESTORE) |->
      ($past(phase) == PH_RESET || $past(phase) == PH_SAVE || $past(phase) == PH_ENTRY_HS));

   p_err_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> (phase == PH_ACTIVE));
endmodule

bind core_sleep_seq core_sleep_seq_chk u_chk (.*);

// File: tb/core_sleep_seq_test.sv
module core_sleep_seq_test;
   localparam int TW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic idle_req = 0, save_done = 0, cs_ack = 0, vr_ready = 1, wake_irq = 0;
   logic pll_lock = 0, restore_done = 0, snoop_req = 0;
   logic [TW-1:0] tmo_limit = 8'd20;
   logic save_go, cache_shrink, cs_enter, vid_low, snoop_blk, core_rst;
   logic restore_go, cache_expand, resume, err, snoop_fwd;
   logic [2:0] phase;

   int n_chk = 0, n_bad = 0;

   always #10 clk = ~clk;

   core_sleep_seq #(.TW(TW)) uut (.*);

   task automatic tick();
      @(posedge clk);
      #5;
   endtask

   task automatic chk(input string tag, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   // one-cycle strobe of a handshake input, then sample
   task automatic go_save();     idle_req = 1;  tick(); idle_req = 0;  endtask
   task automatic go_entry();    save_done = 1; tick(); save_done = 0; endtask
   task automatic go_vrdown();   cs_ack = 1;    tick(); cs_ack = 0;    endtask
   task automatic go_deep();     vr_ready = 0;  tick();                endtask
   task automatic go_wake();     wake_irq = 1;  tick(); wake_irq = 0;  endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog (all R): got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      // R1 reset
      tick(); tick();
      chk("R1 phase in reset", phase, 0);
      chk("R1 outputs in reset",
          {save_go, cache_shrink, cs_enter, vid_low, snoop_blk, core_rst,
           restore_go, cache_expand, resume, err}, 0);
      rst_n = 1;
      tick();
      chk("R1 phase after reset", phase, 0);

      // full round trip
      go_save();
      chk("R2 save phase", phase, 1);
      chk("R2 save cmds", {save_go, cache_shrink, cs_enter}, 3'b110);
      go_entry();
      chk("R2 entry phase", phase, 2);
      chk("R2 cs_enter", cs_enter, 1);
      go_vrdown();
      chk("R3 vr down phase", phase, 3);
      chk("R3 vid_low/snoop_blk", {vid_low, snoop_blk}, 2'b11);
      go_deep();
      chk("R3 deep phase", phase, 4);
      snoop_req = 1;
      for (int k = 0; k < 30; k++) tick();
      chk("R4 deep holds under snoops and no timeout", phase, 4);
      chk("R4 snoop not forwarded", {snoop_fwd, vid_low, snoop_blk}, 3'b011);
      go_wake();
      chk("R4 wake phase", phase, 5);
      chk("R4 vid raised", vid_low, 0);
      vr_ready = 1; tick();
      chk("R5 reset phase", phase, 6);
      chk("R5 core_rst", core_rst, 1);
      pll_lock = 1; tick(); pll_lock = 0;
      chk("R5 restore phase", phase, 7);
      chk("R5 restore cmds", {restore_go, cache_expand, core_rst}, 3'b110);
      restore_done = 1; tick(); restore_done = 0;
      chk("R5 back to active", phase, 0);
      chk("R5 resume pulse", resume, 1);
      tick();
      chk("R5 resume single cycle", resume, 0);
      chk("R10 snoop forwarded when active", snoop_fwd, 1);
      chk("R7 no error on clean trip", err, 0);
      snoop_req = 0;

      // R6 abort from save and from entry handshake
      go_save();
      go_wake();
      chk("R6 abort from save -> restore", phase, 7);
      chk("R6 no core reset", core_rst, 0);
      restore_done = 1; tick(); restore_done = 0;
      chk("R6 abort resumes", {phase, resume}, 4'b0001);
      go_save(); go_entry();
      go_wake();
      chk("R6 abort from entry -> restore", phase, 7);
      restore_done = 1; tick(); restore_done = 0;

      // R7 timeout sweep in the save phase
      for (int L = 0; L < 6; L++) begin
         tmo_limit = L[TW-1:0];
         go_save();
         chk("R8 err cleared on entry", err, 0);
         for (int k = 0; k < L; k++) begin
            tick();
            chk("R7 still waiting", phase, 1);
         end
         tick();
         chk("R7 timeout returns to active", phase, 0);
         chk("R7 err set", err, 1);
         tick(); tick();
         chk("R8 err held while idle", err, 1);
      end

      // R7 timeout in entry handshake and wake phases
      tmo_limit = 8'd2;
      go_save(); go_entry();
      tick(); tick();
      chk("R7 entry still waiting", phase, 2);
      tick();
      chk("R7 entry timeout", {phase, err}, 4'b0001);
      go_save(); go_entry(); go_vrdown(); go_deep();
      for (int k = 0; k < 8; k++) tick();
      chk("R4 deep ignores timeout", phase, 4);
      go_wake();
      tick(); tick();
      chk("R7 wake still waiting", phase, 5);
      tick();
      chk("R7 wake timeout", {phase, err}, 4'b0001);
      vr_ready = 1; tick();

      // R9 priorities at the expiry cycle (limit 2 -> third cycle in phase)
      go_save();
      tick(); tick();
      save_done = 1; wake_irq = 1; tick(); save_done = 0; wake_irq = 0;
      chk("R9 abort beats progress", phase, 7);
      restore_done = 1; tick(); restore_done = 0;
      go_save();
      tick(); tick();
      go_entry();
      chk("R9 progress beats timeout", phase, 2);
      chk("R9 no error", err, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule